// File: doc/BRIEF.md
# Programmable 8-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, resolves them by fixed priority and raises a single interrupt line to the processor. When the processor acknowledges, the block returns an 8-bit vector. The vector is a programmed base combined with the index of the winning input. Requests and in-service levels are tracked in fully nested order: a request reaches the processor only when it outranks everything currently being serviced.

Software sees two command addresses and one trigger-mode address. A write to the command address with bit 4 set starts a short setup sequence. Further words on the auxiliary address complete that sequence. After setup, the same two addresses carry mask writes, end-of-service commands and the choice of which internal register the command address reads back. Each input can be set to edge or level sensing.

Top module: `pic8_top`

## Requirements
- R1: After reset, int_o is low and vector_o is 0. The mask reads 0xFF at address 1, the trigger register reads 0x00 at address 2 and the request register reads 0x00 at address 0.
- R2: A write to address 0 with bit 4 set starts setup in any state. It clears the mask and the in-service register, selects the request register for address-0 reads, and sets every trigger bit to data bit 3 (1 = level, 0 = edge). Data bit 0 records whether a fourth setup word follows.
- R3: After the starting write, the next address-1 writes are taken in order. The first gives the vector base (bits 7:3). The second is accepted with no effect. The third is taken only if bit 0 of the starting write was set. int_o stays low until the sequence completes.
- R4: Once setup is complete, a write to address 1 loads the mask, where a 1 disables that input. Address 1 reads back the mask.
- R5: Address 2 is the per-input trigger register, read and write in any state. Bit n set to 1 makes input n level-sensitive; 0 makes it edge-triggered.
- R6: For an edge-triggered input, a rising edge sets its request bit one cycle later. The bit stays set after the input falls, until that input is acknowledged.
- R7: For a level-sensitive input, the request bit follows the input in the same cycle, and an acknowledge does not clear it.
- R8: Input 0 has the highest priority. int_o is high when the lowest-indexed unmasked request has a lower index than every in-service bit. vector_o then equals {base[7:3], index[2:0]}; otherwise vector_o is 0.
- R9: inta_i sampled while int_o is high sets the winner's in-service bit and clears its request when it is edge-triggered. inta_i while int_o is low has no effect.
- R10: After setup, an address-0 write with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-indexed set in-service bit. Other values with bits 4:3 = 00 change nothing.
- R11: After setup, an address-0 write with bits 4:3 = 01 and bit 1 = 1 selects the in-service register (bit 0 = 1) or the request register (bit 0 = 0) for address-0 reads. With bit 1 = 0 the selection is unchanged.
- R12: If an end-of-service command and an acknowledge fall in the same cycle, the command clears the old lowest in-service bit and the acknowledge then sets the new one. If a new rising edge arrives on the acknowledged input in that same cycle, its request stays set.
- R13: Before the first setup, address-0 writes without bit 4 and all address-1 writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 command, 1 auxiliary, 2 trigger mode |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_i | input | 8 | Interrupt request lines |
| inta_i | input | 1 | Interrupt acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector of the current winner |

## Verification
Two pairs of events can land in the same clock. In the first, an end-of-service command arrives in the same cycle as an acknowledge, and the in-service register must show the old bit cleared and the new bit set. In the second, a fresh rising edge arrives on the very input being acknowledged, and its request must survive the acknowledge. The bench drives both in one cycle each and then reads back the in-service and request registers through address 0. A behavioural model compares int_o, vector_o and rdata_o on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {ST_OFF, ST_W2, ST_W3, ST_W4, ST_RUN} init_st_e;
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_AUX  = 2'd1;
  localparam logic [1:0] A_TRIG = 2'd2;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl import pic_pkg::*; #(
  parameter int NUM_IN = 8,
  parameter int DW     = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic                ready_o,
  output logic                icw1_o,
  output logic                eoi_o,
  output logic                rd_isr_o,
  output logic [NUM_IN-1:0]   imr_o,
  output logic [NUM_IN-1:0]   trig_o,
  output logic [DW-1:IDX_W]   base_o
);
  init_st_e st_q;
  logic need4_q;
  logic cmd_wr, aux_wr, ocw, ocw3;

  assign cmd_wr  = wr_en_i && addr_i == A_CMD;
  assign aux_wr  = wr_en_i && addr_i == A_AUX;
  assign icw1_o  = cmd_wr && wdata_i[4];
  assign ocw     = cmd_wr && !wdata_i[4] && st_q == ST_RUN;
  assign eoi_o   = ocw && !wdata_i[3] && wdata_i[7:5] == 3'b001;
  assign ocw3    = ocw && wdata_i[3];
  assign ready_o = st_q == ST_RUN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OFF;
      need4_q  <= 1'b0;
      rd_isr_o <= 1'b0;
      imr_o    <= '1;
      trig_o   <= '0;
      base_o   <= '0;
    end else begin
      if (icw1_o) begin
        st_q     <= ST_W2;
        need4_q  <= wdata_i[0];
        rd_isr_o <= 1'b0;
        imr_o    <= '0;
        trig_o   <= {NUM_IN{wdata_i[3]}};
      end else if (aux_wr) begin
        unique case (st_q)
          ST_W2: begin
            base_o <= wdata_i[DW-1:IDX_W];
            st_q   <= ST_W3;
          end
          ST_W3:   st_q  <= need4_q ? ST_W4 : ST_RUN;
          ST_W4:   st_q  <= ST_RUN;
          ST_RUN:  imr_o <= wdata_i[NUM_IN-1:0];
          default: ;
        endcase
      end else if (ocw3 && wdata_i[1]) begin
        rd_isr_o <= wdata_i[0];
      end
      if (wr_en_i && addr_i == A_TRIG) trig_o <= wdata_i[NUM_IN-1:0];
    end
  end

  p_icw1_clears_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw1_o |=> (imr_o == '0 && !rd_isr_o && st_q == ST_W2));
  p_off_no_skip_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF) |=> (st_q == ST_OFF || st_q == ST_W2));
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int NUM_IN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic [NUM_IN-1:0] trig_i,
  input  logic [NUM_IN-1:0] ack_oh_i,
  output logic [NUM_IN-1:0] irr_o
);
  logic [NUM_IN-1:0] prev_q, edge_q, rise;

  assign rise = irq_i & ~prev_q & ~trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= irq_i;
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) edge_q[g] <= 1'b0;
      else edge_q[g] <= (edge_q[g] & ~(ack_oh_i[g] & ~trig_i[g])) | rise[g];
    end
    assign irr_o[g] = trig_i[g] ? irq_i[g] : edge_q[g];
  end

  // new edge wins over an acknowledge in the same cycle
  p_edge_latched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((edge_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int NUM_IN = 8,
  parameter int DW     = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irr_i,
  input  logic [NUM_IN-1:0] imr_i,
  input  logic              ready_i,
  input  logic              inta_i,
  input  logic              eoi_i,
  input  logic              clr_i,
  input  logic [DW-1:IDX_W] base_i,
  output logic              int_o,
  output logic [DW-1:0]     vector_o,
  output logic [NUM_IN-1:0] ack_oh_o,
  output logic [NUM_IN-1:0] isr_o
);
  logic [NUM_IN-1:0] pend, win_oh, isr_low;
  logic [IDX_W-1:0]  win_idx;

  assign pend    = irr_i & ~imr_i;
  assign win_oh  = pend & (~pend + 1'b1);
  assign isr_low = isr_o & (~isr_o + 1'b1);

  always_comb begin
    win_idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--)
      if (pend[i]) win_idx = IDX_W'(i);
  end

  // fully nested: no in-service bit at or above the winner's level
  assign int_o    = ready_i && |pend && (isr_o & (win_oh | (win_oh - 1'b1))) == '0;
  assign vector_o = int_o ? {base_i, win_idx} : '0;
  assign ack_oh_o = (inta_i && int_o) ? win_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    isr_o <= '0;
    else if (clr_i) isr_o <= '0;
    else            isr_o <= (isr_o & ~(eoi_i ? isr_low : '0)) | ack_oh_o;
  end

  p_ack_sets_isr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !clr_i) |=> ((isr_o & $past(ack_oh_o)) != '0));
  p_eoi_one_bit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !clr_i && !(inta_i && int_o) && isr_o != '0)
      |=> ($countones(isr_o) + 1 == $countones($past(isr_o))));
  p_icw1_clears_isr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (isr_o == '0));
endmodule

// File: rtl/pic8_top.sv
module pic8_top import pic_pkg::*; #(
  parameter int NUM_IN = 8,
  parameter int DW     = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic              inta_i,
  output logic              int_o,
  output logic [DW-1:0]     vector_o
);
  logic ready, icw1, eoi, rd_isr;
  logic [NUM_IN-1:0] imr, trig, irr, isr, ack_oh;
  logic [DW-1:IDX_W] base;

  pic_ctrl #(.NUM_IN(NUM_IN), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ready_o(ready), .icw1_o(icw1), .eoi_o(eoi), .rd_isr_o(rd_isr),
    .imr_o(imr), .trig_o(trig), .base_o(base)
  );

  pic_req #(.NUM_IN(NUM_IN)) u_req (
    .clk_i, .rst_ni, .irq_i, .trig_i(trig), .ack_oh_i(ack_oh), .irr_o(irr)
  );

  pic_prio #(.NUM_IN(NUM_IN), .DW(DW)) u_prio (
    .clk_i, .rst_ni, .irr_i(irr), .imr_i(imr), .ready_i(ready),
    .inta_i, .eoi_i(eoi), .clr_i(icw1), .base_i(base),
    .int_o, .vector_o, .ack_oh_o(ack_oh), .isr_o(isr)
  );

  always_comb begin
    unique case (addr_i)
      A_CMD:   rdata_o = DW'(rd_isr ? isr : irr);
      A_AUX:   rdata_o = DW'(imr);
      A_TRIG:  rdata_o = DW'(trig);
      default: rdata_o = '0;
    endcase
  end

  p_no_int_unready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw1 |=> !int_o);
endmodule

// File: tb/pic8_top_test.sv
module pic8_top_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0, inta_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00, irq_i = 8'h00;
  logic [7:0] rdata_o, vector_o;
  logic int_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  pic8_top uut (.clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
                .irq_i, .inta_i, .int_o, .vector_o);

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  bit [7:0] m_imr, m_isr, m_trig, m_edg, m_prev, m_base;
  int m_st;
  bit m_need4, m_sel;

  function automatic bit [7:0] m_irr();
    return (m_trig & irq_i) | (~m_trig & m_edg);
  endfunction

  function automatic int m_win();
    bit [7:0] p = m_irr() & ~m_imr;
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic bit m_ok();
    int w = m_win();
    if (m_st != 4 || w < 0) return 0;
    for (int j = 0; j <= w; j++) if (m_isr[j]) return 0;
    return 1;
  endfunction

  function automatic bit [7:0] m_rd();
    case (addr_i)
      2'd0: return m_sel ? m_isr : m_irr();
      2'd1: return m_imr;
      2'd2: return m_trig;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_imr = 8'hFF; m_isr = 0; m_trig = 0; m_edg = 0; m_prev = 0; m_base = 0;
      m_st = 0; m_need4 = 0; m_sel = 0;
    end else begin
      int w;
      bit ack;
      bit [7:0] n_isr, n_edg;
      w = m_win();
      ack = inta_i && m_ok();
      n_isr = m_isr;
      n_edg = m_edg;
      if (wr_en_i && addr_i == 0 && m_st == 4 && wdata_i[4:3] == 0 && wdata_i[7:5] == 1)
        for (int j = 0; j < 8; j++) if (n_isr[j]) begin n_isr[j] = 0; break; end
      if (ack) begin
        n_isr[w] = 1;
        if (!m_trig[w]) n_edg[w] = 0;
      end
      for (int i = 0; i < 8; i++) if (irq_i[i] && !m_prev[i] && !m_trig[i]) n_edg[i] = 1;
      if (wr_en_i && addr_i == 0 && wdata_i[4]) begin
        m_st = 1; m_need4 = wdata_i[0]; m_sel = 0; m_imr = 0; n_isr = 0;
        m_trig = wdata_i[3] ? 8'hFF : 8'h00;
      end else if (wr_en_i && addr_i == 1) begin
        if (m_st == 1) begin m_base = wdata_i & 8'hF8; m_st = 2; end
        else if (m_st == 2) m_st = m_need4 ? 3 : 4;
        else if (m_st == 3) m_st = 4;
        else if (m_st == 4) m_imr = wdata_i;
      end else if (wr_en_i && addr_i == 0 && m_st == 4 && wdata_i[4:3] == 2'b01 && wdata_i[1]) begin
        m_sel = wdata_i[0];
      end else if (wr_en_i && addr_i == 2) begin
        m_trig = wdata_i;
      end
      m_isr = n_isr;
      m_edg = n_edg;
      m_prev = irq_i;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit [7:0] ev;
    @(negedge clk);
    if (!rst_ni) return;
    ev = m_ok() ? (m_base | 8'(m_win())) : 8'h00;
    chk(int_o == m_ok(), cur_req, "model int_o", int_o, m_ok());
    chk(vector_o == ev, cur_req, "model vector_o", vector_o, ev);
    chk(rdata_o == m_rd(), cur_req, "model rdata_o", rdata_o, m_rd());
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 0;
  endtask

  task automatic ack();
    inta_i = 1;
    tick();
    inta_i = 0;
  endtask

  task automatic rd(input bit [1:0] a, input bit [7:0] exp, input string req);
    addr_i = a;
    #1;
    chk(rdata_o == exp, req, "rdata_o", rdata_o, exp);
  endtask

  task automatic irq(input bit exp_int, input bit [7:0] exp_vec, input string req);
    #1;
    chk(int_o == exp_int, req, "int_o", int_o, exp_int);
    chk(vector_o == exp_vec, req, "vector_o", vector_o, exp_vec);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    cur_req = "R1";
    irq(0, 8'h00, "R1");
    rd(1, 8'hFF, "R1"); rd(2, 8'h00, "R1"); rd(0, 8'h00, "R1");

    cur_req = "R13";
    wr(0, 8'h20); wr(1, 8'h00);
    rd(1, 8'hFF, "R13");
    irq_i = 8'h01; tick(); tick();
    irq(0, 8'h00, "R3");

    cur_req = "R2";
    wr(0, 8'h11);
    rd(1, 8'h00, "R2"); rd(2, 8'h00, "R2");
    cur_req = "R3";
    wr(1, 8'h45); wr(1, 8'h04);
    irq(0, 8'h00, "R3");
    wr(1, 8'h01);
    irq(1, 8'h40, "R3");
    rd(0, 8'h01, "R2");

    cur_req = "R4";
    wr(1, 8'h01);
    irq(0, 8'h00, "R4"); rd(1, 8'h01, "R4");
    wr(1, 8'h00);
    irq(1, 8'h40, "R4");

    cur_req = "R9";
    ack();
    irq(0, 8'h00, "R9"); rd(0, 8'h00, "R9");
    cur_req = "R11";
    wr(0, 8'h0B); rd(0, 8'h01, "R11");
    wr(0, 8'h08); rd(0, 8'h01, "R11");

    cur_req = "R8";
    irq_i = 8'h09; tick();
    irq(0, 8'h00, "R8");
    cur_req = "R10";
    wr(0, 8'h60); rd(0, 8'h01, "R10");
    wr(0, 8'h20); rd(0, 8'h00, "R10");
    irq(1, 8'h43, "R10");
    ack();
    irq_i = 8'h0B; tick();
    irq(1, 8'h41, "R8");

    cur_req = "R12";
    inta_i = 1; wr(0, 8'h20); inta_i = 0;
    rd(0, 8'h02, "R12");
    irq(0, 8'h00, "R12");
    wr(0, 8'h20); rd(0, 8'h00, "R10");

    cur_req = "R6";
    irq_i = 8'h0F; tick();
    irq_i = 8'h0B; tick();
    irq(1, 8'h42, "R6");
    wr(0, 8'h0A); rd(0, 8'h04, "R6");

    cur_req = "R12";
    irq_i = 8'h0F; ack();
    rd(0, 8'h04, "R12");
    irq(0, 8'h00, "R12");
    wr(0, 8'h20);
    irq(1, 8'h42, "R12");
    ack(); wr(0, 8'h20);
    irq(0, 8'h00, "R9");

    cur_req = "R5";
    wr(2, 8'h10); rd(2, 8'h10, "R5");
    cur_req = "R7";
    irq_i = 8'h1F;
    rd(0, 8'h10, "R7");
    irq(1, 8'h44, "R7");
    ack();
    rd(0, 8'h10, "R7");
    irq_i = 8'h0F;
    rd(0, 8'h00, "R7");
    wr(0, 8'h20);

    cur_req = "R9";
    ack();
    wr(0, 8'h0B); rd(0, 8'h00, "R9");

    cur_req = "R2";
    wr(0, 8'h18);
    rd(2, 8'hFF, "R2");
    irq(0, 8'h00, "R3");
    cur_req = "R3";
    wr(1, 8'h80); wr(1, 8'h00);
    irq(1, 8'h80, "R3");
    rd(0, 8'h0F, "R2");
    cur_req = "R4";
    wr(1, 8'hFF);
    irq(0, 8'h00, "R4");
    tick(); tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule